// File: doc/BRIEF.md
# Filtered Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus that lets a host read and write a bank of 8-bit configuration registers. By default there are 44 registers, indexed 0x00 to 0x2B. The block runs from a local reference clock. Each bus line first passes through a filter, and the block then works from the filtered lines. A filtered line changes only after the raw line has held a new level for three reference clocks, so shorter spikes are lost.

A write transaction sends the device address with the direction bit clear, then a pointer byte, then any number of data bytes. The pointer selects a register, and every data byte after it lands in the next register. A read usually follows a pointer write through a repeated START. It returns bytes from the pointer onward, advancing the pointer after each byte, until the host answers a byte with a NACK.

The control is one state machine with these states:
- ST_IDLE: not addressed.
- ST_ADDR: shifting in the address byte.
- ST_ADDR_ACK: acknowledging the address.
- ST_PTR and ST_PTR_ACK: receiving and acknowledging the pointer byte.
- ST_WDATA and ST_WDATA_ACK: receiving and acknowledging a data byte.
- ST_RDATA: shifting out a byte.
- ST_RACK: sampling the host's acknowledge.

These transitions apply from the named states:
- A START from any state goes to ST_ADDR.
- A STOP from any state goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on a matching address and to ST_IDLE otherwise.
- ST_ADDR_ACK goes to ST_PTR for a write and to ST_RDATA for a read.
- ST_PTR goes to ST_PTR_ACK, and ST_PTR_ACK goes to ST_WDATA.
- ST_WDATA and ST_WDATA_ACK alternate.
- ST_RDATA goes to ST_RACK. ST_RACK goes back to ST_RDATA on a host ACK and to ST_IDLE on a NACK.

Every move in the byte and acknowledge phases happens on a falling edge of the filtered SCL.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset, sda_oe is 0, the register pointer is 0x00 and every register reads 0x00.
- R2: A pulse on SCL or SDA lasting fewer than 3 reference clocks has no effect on the transfer.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bus clocks before any START are never acknowledged. A STOP returns the block to idle with SDA released.
- R4: The block answers only the 7-bit address made of binary 100110 followed by the addr_lsb strap. It answers by driving SDA low during the ninth clock. For any other address it never drives SDA until the next START.
- R5: The bit after the 7 address bits selects the direction: 0 means write and 1 means read.
- R6: In a write, the first byte loads the pointer. Each later byte is stored at the pointer, after which the pointer advances by one. Every byte of a write is acknowledged.
- R7: After a repeated START with a read address, the block returns the register at the pointer MSB first, advancing the pointer after each byte.
- R8: Incoming bits are taken on the rising edge of the filtered SCL. sda_oe changes only while SCL is low.
- R9: When the host answers a read byte with a NACK (SDA high on the ninth clock), the block releases SDA and drives nothing more until the next START.
- R10: Writes to pointer values at or above the register count are acknowledged and discarded, and reads from them return 0x00.
- R11: Advancing the pointer from the last register (0x2B) gives 0x00.
- R12: SDA is open-drain: sda_oe = 1 pulls the line low, and sda_oe = 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| addr_lsb | input | 1 | Strap that sets the lowest address bit |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the ports is a spike that is too short to count but that arrives exactly where an unfiltered line would do harm. A short SCL high pulse during the low phase of a data bit would add a bit. A short SDA low pulse while SCL is high would look like a START. The bench bit-bangs these spikes, two clocks wide, into the middle of a data byte. It then reads the register back, so any extra bit or false START shows up as a wrong byte. A second hard case is the point where the pointer steps from the last register to 0x00 during a burst. The bench reaches it with a burst that starts at 0x2B and a read that starts at 0x2A.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tws_state_e;

    // fixed upper six bits of the device address
    localparam logic [5:0] DEV_PREFIX = 6'b100110;

endpackage

// File: rtl/tws_deglitch.sv
module tws_deglitch #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [FILT-1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '1;
            dout <= 1'b1;
        end else begin
            hist <= {hist[FILT-2:0], din};
            if (&hist) begin
                dout <= 1'b1;
            end else if (~|hist) begin
                dout <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tws_regbank.sv
module tws_regbank #(
    parameter int NUM_REGS = 44,
    parameter int AW       = 8,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [NUM_REGS];

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (wr_en && wr_addr == AW'(g)) begin
                    regs[g] <= wr_data;
                end
            end
        end
    endgenerate

    // out-of-range pointers fall through to zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = regs[i];
            end
        end
    end
endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave
    import tws_pkg::*;
#(
    parameter int NUM_REGS = 44,
    parameter int FILT     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_lsb,
    output logic sda_oe
);
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS + 1);
    localparam logic [AW-1:0] LAST_REG = AW'(NUM_REGS - 1);

    // ---------------- line filters ----------------
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    assign raw_lines = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_line
            tws_deglitch #(.FILT(FILT)) u_flt (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_lines[g]),
                .dout (filt_lines[g])
            );
        end
    endgenerate

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

    // ---------------- datapath signals ----------------
    tws_state_e     state, nxt;
    logic [CW-1:0]  cnt;
    logic [DW-1:0]  rx_sh, tx_sh;
    logic [AW-1:0]  ptr, ptr_inc;
    logic [DW-1:0]  rd_data;
    logic           host_ack;
    logic           byte_done, addr_hit, wr_en;

    assign byte_done = (cnt == CW'(BITS));
    assign addr_hit  = (rx_sh[7:1] == {DEV_PREFIX, addr_lsb});
    assign ptr_inc   = (ptr == LAST_REG) ? '0 : ptr + 1'b1;
    assign wr_en     = (state == ST_WDATA) && scl_fall && byte_done;

    tws_regbank #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(DW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(ptr),
        .wr_data(rx_sh),
        .rd_addr(ptr),
        .rd_data(rd_data)
    );

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  nxt = rx_sh[0] ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RACK;
                ST_RACK:      nxt = host_ack ? ST_RDATA : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_ev || stop_ev) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sda_oe <= 1'b0;
                end
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sh <= {rx_sh[DW-2:0], sda_f};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            sda_oe <= addr_hit;
                        end else if (state == ST_PTR) begin
                            ptr    <= rx_sh;
                            sda_oe <= 1'b1;
                        end else begin
                            ptr    <= ptr_inc;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        if (state == ST_ADDR_ACK && rx_sh[0]) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[DW-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr_inc;
                        end else begin
                            tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                            sda_oe <= ~tx_sh[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_f;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (host_ack) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[DW-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tws_checker.sv
module tws_checker
    import tws_pkg::*;
#(
    parameter int NUM_REGS = 44
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       wr_en,
    input tws_state_e state,
    input logic [7:0] ptr,
    input logic       sda_oe
);
    p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    p_start_to_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    p_stop_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

    p_drive_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr < 8'(NUM_REGS - 1)) |=> (ptr == $past(ptr) + 8'd1));

    p_ptr_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 8'(NUM_REGS - 1)) |=> (ptr == 8'd0));
endmodule

bind cfg_twowire_slave tws_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .wr_en   (wr_en),
    .state   (state),
    .ptr     (ptr),
    .sda_oe  (sda_oe)
);

// File: tb/cfg_twowire_slave_tb.sv
`timescale 1ns/1ps
module cfg_twowire_slave_tb;
    localparam int NREG = 44;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic strap = 1'b0;
    logic sda_oe;
    logic sda_line;

    always #10 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    cfg_twowire_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_drv),
        .sda_i   (sda_line),
        .addr_lsb(strap),
        .sda_oe  (sda_oe)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [NREG];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];

    logic oe_prev = 1'b0;
    logic oe_seen = 1'b0;
    int   oe_bad  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R8 monitor: the slave may only move SDA while the clock is low
    always @(negedge clk) begin
        if (sda_oe !== oe_prev && scl_drv) oe_bad++;
        oe_prev = sda_oe;
        if (sda_oe) oe_seen = 1'b1;
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] gv, ev;
                string      tg;
                gv = got_q.pop_front();
                ev = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(gv == ev, tg, gv, ev);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq();
        scl_drv = 1'b1; wq();
        sda_drv = 1'b0; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq();
        scl_drv = 1'b1; wq();
        sda_drv = 1'b1; wq();
    endtask

    // glitch: 0 none, 1 short SCL pulse while low, 2 short SDA dip while high
    task automatic send_bit(input logic b, input int glitch);
        sda_drv = b;
        if (glitch == 1) begin
            repeat (4) @(negedge clk);
            scl_drv = 1'b1;
            repeat (2) @(negedge clk);
            scl_drv = 1'b0;
            repeat (Q - 6) @(negedge clk);
        end else begin
            wq();
        end
        scl_drv = 1'b1;
        if (glitch == 2) begin
            repeat (4) @(negedge clk);
            sda_drv = 1'b0;
            repeat (2) @(negedge clk);
            sda_drv = b;
            repeat (2 * Q - 6) @(negedge clk);
        end else begin
            wq(); wq();
        end
        scl_drv = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; wq();
        scl_drv = 1'b1; wq();
        b = sda_line;
        wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic bit_v;
        for (int i = 7; i >= 0; i--) send_bit(v[i], 0);
        recv_bit(bit_v);
        ack = ~bit_v;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        logic bit_v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(bit_v);
            v[i] = bit_v;
        end
        send_bit(~give_ack, 0);
    endtask

    function automatic logic [7:0] step(input logic [7:0] p);
        return (p == 8'(NREG - 1)) ? 8'h00 : p + 8'd1;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] p);
        return (p < 8'(NREG)) ? model[p] : 8'h00;
    endfunction

    task automatic wr_seq(input logic [6:0] dev, input logic [7:0] p, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input string req);
        logic ack;
        logic [7:0] dv;
        bus_start();
        write_byte({dev, 1'b0}, ack); chk(ack, "R5 write address ack", ack, 1);
        write_byte(p, ack);           chk(ack, "R6 pointer ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            dv = (i == 0) ? d0 : d1;
            write_byte(dv, ack);
            chk(ack, req, ack, 1);
            if (p < 8'(NREG)) model[p] = dv;
            p = step(p);
        end
        bus_stop();
    endtask

    task automatic rd_seq(input logic [6:0] dev, input logic [7:0] p, input int n, input string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        write_byte({dev, 1'b0}, ack); chk(ack, "R4 address ack", ack, 1);
        write_byte(p, ack);           chk(ack, "R6 pointer ack", ack, 1);
        bus_start();
        write_byte({dev, 1'b1}, ack); chk(ack, "R7 read address ack after repeated START", ack, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model_rd(p));
            tag_q.push_back(req);
            p = step(p);
            read_byte(i < n - 1, v);
            got_q.push_back(v);
        end
        chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic finish_run();
        while (got_q.size() > 0) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset output
        chk(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);

        // R3 clocks without START: a matching address pattern gets no answer
        scl_drv = 1'b0; wq();
        oe_seen = 1'b0;
        write_byte(8'h98, ack);
        chk(!oe_seen, "R3 no drive before START", oe_seen, 0);
        bus_stop();

        // R1/R7 direct read from reset pointer 0x00
        bus_start();
        write_byte(8'h99, ack); chk(ack, "R5 read address ack", ack, 1);
        read_byte(1'b1, v); chk(v == 8'h00, "R1 reg0 reset value", v, 0);
        read_byte(1'b0, v); chk(v == 8'h00, "R1 reg1 reset value", v, 0);
        chk(sda_oe == 1'b0, "R9 release after NACK", sda_oe, 0);
        bus_stop();

        // R4 wrong strap bit: ignored
        oe_seen = 1'b0;
        bus_start();
        write_byte(8'h9A, ack);
        write_byte(8'h00, ack);
        chk(!oe_seen, "R4 mismatched address never driven", oe_seen, 0);
        bus_stop();

        // R6/R7 burst write and read back
        wr_seq(7'h4C, 8'h05, 2, 8'hA1, 8'hB2, "R6 data ack");
        wr_seq(7'h4C, 8'h07, 1, 8'hC3, 8'h00, "R6 data ack");
        rd_seq(7'h4C, 8'h05, 3, "R7 burst read data");

        // R11 wrap from last register
        wr_seq(7'h4C, 8'h2B, 2, 8'h77, 8'h11, "R11 ack across wrap");
        rd_seq(7'h4C, 8'h2A, 3, "R11 read across wrap");

        // R10 out of range
        wr_seq(7'h4C, 8'h30, 1, 8'h55, 8'h00, "R10 out-of-range write ack");
        rd_seq(7'h4C, 8'h30, 2, "R10 out-of-range read zero");
        rd_seq(7'h4C, 8'h00, 1, "R10 in-range register untouched");

        // R2 glitches inside a data byte 0x5A
        bus_start();
        write_byte(8'h98, ack); chk(ack, "R2 address ack", ack, 1);
        write_byte(8'h10, ack); chk(ack, "R2 pointer ack", ack, 1);
        send_bit(1'b0, 1);
        send_bit(1'b1, 2);
        send_bit(1'b0, 1);
        send_bit(1'b1, 2);
        send_bit(1'b1, 0);
        send_bit(1'b0, 1);
        send_bit(1'b1, 2);
        send_bit(1'b0, 0);
        recv_bit(v[0]);
        chk(v[0] == 1'b0, "R2 data ack despite glitches", v[0], 0);
        bus_stop();
        model[8'h10] = 8'h5A;
        rd_seq(7'h4C, 8'h10, 1, "R2 glitched byte stored intact");

        // R4 strap high moves the address
        strap = 1'b1;
        oe_seen = 1'b0;
        bus_start();
        write_byte(8'h98, ack);
        chk(!oe_seen, "R4 old address ignored with strap high", oe_seen, 0);
        bus_stop();
        wr_seq(7'h4D, 8'h20, 1, 8'h3C, 8'h00, "R4 strap address data ack");
        rd_seq(7'h4D, 8'h20, 1, "R4 strap address read");

        // R8/R12 SDA only moved while SCL low
        chk(oe_bad == 0, "R8 sda_oe moved while SCL high", oe_bad, 0);
        finish_run();
    end
endmodule